// File: doc/BRIEF.md
# SerDes Management Register Bridge

This block lives in a root-complex configuration space and gives software indirect access to the 16-bit control registers inside a set of SerDes macros. Software writes a PHY address word, selects a macro, and then launches a transaction by setting a command bit in the data/command register. The bridge turns that into one request on a parallel management port, holds the request until the macro acknowledges it, and reports completion through bits that software polls.

A write completes when its command bit clears by itself. A read completes when a separate acknowledge bit rises in the read-data register, with the returned halfword in the low bits. The lane field of the address picks one lane of the selected macro, and the all-ones value addresses every lane at once. Badly formed commands, commands issued while busy, and requests that the macro never answers end with a sticky error flag. None of these cases hangs the bridge.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset every readable register (offsets 0x1130, 0x1134, 0x1138, 0x113C) reads zero and `phy_req` is low.
- R2: Offset 0x1130 holds a 32-bit PHY address word that reads back unchanged. Offset 0x113C holds the macro select in its low bits. All other offsets read zero.
- R3: Writing offset 0x1134 with bit 31 set and bit 30 clear launches a PHY write. Bit 31 of 0x1134 reads 1 while the write is in flight and clears by itself once `phy_ack` is seen. Only bits 15:0 of the written word reach `phy_wdata`.
- R4: Writing 0x1134 with only bit 30 set launches a PHY read. When the read completes, bit 31 of 0x1138 (the read-ack) reads 1 and bits 15:0 hold `phy_rdata`. The read-ack clears when the next command is accepted.
- R5: The address word has this layout: bit 27 must be 1, bits 24:16 are the lane, bits 15:0 are the register. A command whose address has bit 27 clear starts no transaction and sets the error flag.
- R6: Lane values 0 and 1 drive a one-hot `phy_lane_mask` for that lane. Lane 0x1FF on a write drives every mask bit. Lane 0x1FF on a read drives only lane 0. Any other lane value starts no transaction and sets the error flag.
- R7: A write to 0x1134 while a transaction is in flight is ignored: the stored write data, the in-flight request and its completion are unchanged. If that write carries a command bit, the error flag is set.
- R8: A command word with both bit 31 and bit 30 set starts no transaction and sets the error flag.
- R9: If no `phy_ack` arrives within TIMEOUT_CYC cycles of the request being raised, the request drops, both busy bits clear, the error flag is set and the read-ack stays 0.
- R10: The error flag is bit 29 of 0x1134. It stays set through later successful transactions and clears only when 0x1134 is written with bit 29 set.
- R11: While `phy_req` is high and no ack has arrived, `phy_sel`, `phy_lane_mask`, `phy_reg` and `phy_wdata` hold the values captured at launch, even if the select or address registers are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config offset for both reads and writes |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_addr`, combinational |
| phy_req | output | 1 | Management request, held until ack or timeout |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_sel | output | SEL_W | Target SerDes macro |
| phy_lane_mask | output | NUM_LANES | Lanes addressed |
| phy_reg | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle completion pulse from the macro |
| phy_rdata | input | 16 | Read data, valid together with `phy_ack` |

## Verification
The assertions watch the management port on every cycle. They check that a request stays stable until it ends, that an ack ends the request, that a read addresses exactly one lane, that a timeout sets the error flag without a read-ack, and that a rejected or colliding command raises the error while leaving the in-flight request alone. Some behaviour only the bench scenarios can show, because it needs a macro model with real storage: that broadcast writes land in both lanes while single-lane writes touch only one, that a broadcast read returns lane 0, that the dropped upper data bits never reach the PHY, and that the timeout fires after exactly the configured number of request cycles.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

  localparam int unsigned OFS_ADDR = 32'h1130;
  localparam int unsigned OFS_DATA = 32'h1134;
  localparam int unsigned OFS_RDAT = 32'h1138;
  localparam int unsigned OFS_SEL  = 32'h113C;
  localparam int unsigned LANE_W   = 9;
  localparam logic [8:0]  LANE_ALL = 9'h1FF;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_BOTH = 2'd3
  } cmd_e;

  // command bits sit in the top two bits of the data/command word
  function automatic cmd_e cmd_decode(input logic [31:0] word);
    case (word[31:30])
      2'b10:   return CMD_WR;
      2'b01:   return CMD_RD;
      2'b11:   return CMD_BOTH;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic addr_fmt_ok(input logic [31:0] a);
    return a[27];
  endfunction

  function automatic logic [LANE_W-1:0] addr_lane(input logic [31:0] a);
    return a[24:16];
  endfunction

  function automatic logic [15:0] addr_reg(input logic [31:0] a);
    return a[15:0];
  endfunction

endpackage

// File: rtl/pmb_regs.sv
module pmb_regs
  import pmb_pkg::*;
#(
  parameter int unsigned CFG_AW = 16,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic              busy_wr,
  input  logic              err,
  input  logic              rack,
  input  logic [15:0]       rdata,
  output logic [31:0]       addr_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [15:0]       wdata_q,
  output logic              cmd_evt,
  output cmd_e              cmd_kind,
  output logic              err_clr
);

  localparam logic [CFG_AW-1:0] A_ADDR = CFG_AW'(OFS_ADDR);
  localparam logic [CFG_AW-1:0] A_DATA = CFG_AW'(OFS_DATA);
  localparam logic [CFG_AW-1:0] A_RDAT = CFG_AW'(OFS_RDAT);
  localparam logic [CFG_AW-1:0] A_SEL  = CFG_AW'(OFS_SEL);

  logic hit_data;
  logic data_store;

  assign hit_data   = cfg_wr_en && (cfg_addr == A_DATA);
  assign cmd_kind   = cmd_decode(cfg_wdata);
  assign cmd_evt    = hit_data && (cmd_kind != CMD_NONE);
  assign err_clr    = hit_data && cfg_wdata[29];
  assign data_store = hit_data && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sel_q   <= '0;
      wdata_q <= '0;
    end else begin
      if (cfg_wr_en && (cfg_addr == A_ADDR)) addr_q <= cfg_wdata;
      if (cfg_wr_en && (cfg_addr == A_SEL))  sel_q  <= cfg_wdata[SEL_W-1:0];
      if (data_store)                        wdata_q <= cfg_wdata[15:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_ADDR: cfg_rdata = addr_q;
      A_DATA: cfg_rdata = {busy && busy_wr, busy && !busy_wr, err, 13'd0, wdata_q};
      A_RDAT: cfg_rdata = {rack, 15'd0, rdata};
      A_SEL:  cfg_rdata = 32'(sel_q);
      default: cfg_rdata = '0;
    endcase
  end

  AST_BUSY_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && busy) |=> $stable(wdata_q)); // R7

endmodule

// File: rtl/pmb_lane_dec.sv
module pmb_lane_dec
  import pmb_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2
) (
  input  logic [LANE_W-1:0]    lane,
  input  logic                 is_write,
  output logic [NUM_LANES-1:0] mask,
  output logic                 lane_ok
);

  logic bcast;
  assign bcast   = (lane == LANE_ALL);
  assign lane_ok = bcast || (32'(lane) < NUM_LANES);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    if (i == 0) begin : g_first
      // broadcast reads are served by the first lane
      assign mask[i] = bcast || (lane == LANE_W'(i));
    end else begin : g_rest
      assign mask[i] = (bcast && is_write) || (lane == LANE_W'(i));
    end
  end

endmodule

// File: rtl/pmb_txn.sv
module pmb_txn
  import pmb_pkg::*;
#(
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned NUM_LANES   = 2,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_evt,
  input  cmd_e                 cmd_kind,
  input  logic                 err_clr,
  input  logic                 addr_ok,
  input  logic [NUM_LANES-1:0] lane_mask,
  input  logic [15:0]          reg_addr,
  input  logic [15:0]          cmd_data,
  input  logic [SEL_W-1:0]     sel,
  output logic                 busy,
  output logic                 busy_wr,
  output logic                 err,
  output logic                 rack,
  output logic [15:0]          rdata,
  output logic [SEL_W-1:0]     phy_sel,
  output logic [NUM_LANES-1:0] phy_lane_mask,
  output logic [15:0]          phy_reg,
  output logic [15:0]          phy_wdata,
  input  logic                 phy_ack,
  input  logic [15:0]          phy_rdata
);

  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);

  logic [TMO_W-1:0] tmo_cnt;
  logic kind_ok, launch, reject, tmo_hit;

  assign kind_ok = (cmd_kind == CMD_WR) || (cmd_kind == CMD_RD);
  assign launch  = cmd_evt && !busy && kind_ok && addr_ok;
  assign reject  = cmd_evt && (busy || !kind_ok || !addr_ok);
  assign tmo_hit = busy && !phy_ack && (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      busy_wr       <= 1'b0;
      rack          <= 1'b0;
      rdata         <= '0;
      tmo_cnt       <= '0;
      phy_sel       <= '0;
      phy_lane_mask <= '0;
      phy_reg       <= '0;
      phy_wdata     <= '0;
    end else if (launch) begin
      busy          <= 1'b1;
      busy_wr       <= (cmd_kind == CMD_WR);
      rack          <= 1'b0;
      tmo_cnt       <= '0;
      phy_sel       <= sel;
      phy_lane_mask <= lane_mask;
      phy_reg       <= reg_addr;
      phy_wdata     <= cmd_data;
    end else if (busy) begin
      if (phy_ack) begin
        busy <= 1'b0;
        if (!busy_wr) begin
          rack  <= 1'b1;
          rdata <= phy_rdata;
        end
      end else if (tmo_hit) begin
        busy <= 1'b0;
      end else begin
        tmo_cnt <= tmo_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                err <= 1'b0;
    else if (reject || tmo_hit) err <= 1'b1;
    else if (err_clr)          err <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phy_ack && !tmo_hit) |=> (busy && $stable(phy_sel) && $stable(phy_lane_mask)
                                        && $stable(phy_reg) && $stable(phy_wdata))); // R11
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phy_ack) |=> !busy); // R3
  AST_LAUNCH_CLR_RACK: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && !rack)); // R4
  AST_READ_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_wr) |-> ($countones(phy_lane_mask) == 1)); // R6
  AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err); // R7
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && busy && !phy_ack && !tmo_hit) |=> (busy && $stable(phy_reg) && $stable(phy_wdata))); // R7
  AST_TMO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (err && !busy && !rack)); // R9

endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import pmb_pkg::*;
#(
  parameter int unsigned CFG_AW      = 16,
  parameter int unsigned NUM_MACROS  = 8,
  parameter int unsigned NUM_LANES   = 2,
  parameter int unsigned TIMEOUT_CYC = 16,
  parameter int unsigned SEL_W       = (NUM_MACROS > 1) ? $clog2(NUM_MACROS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 phy_req,
  output logic                 phy_we,
  output logic [SEL_W-1:0]     phy_sel,
  output logic [NUM_LANES-1:0] phy_lane_mask,
  output logic [15:0]          phy_reg,
  output logic [15:0]          phy_wdata,
  input  logic                 phy_ack,
  input  logic [15:0]          phy_rdata
);

  logic [31:0]          addr_q;
  logic [SEL_W-1:0]     sel_q;
  logic [15:0]          wdata_q;
  logic                 cmd_evt, err_clr;
  cmd_e                 cmd_kind;
  logic                 busy, busy_wr, err, rack;
  logic [15:0]          rdata;
  logic [NUM_LANES-1:0] lane_mask;
  logic                 lane_ok, addr_ok;

  pmb_regs #(.CFG_AW(CFG_AW), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .busy_wr(busy_wr), .err(err), .rack(rack), .rdata(rdata),
    .addr_q(addr_q), .sel_q(sel_q), .wdata_q(wdata_q),
    .cmd_evt(cmd_evt), .cmd_kind(cmd_kind), .err_clr(err_clr)
  );

  pmb_lane_dec #(.NUM_LANES(NUM_LANES)) u_lane (
    .lane(addr_lane(addr_q)), .is_write(cmd_kind == CMD_WR),
    .mask(lane_mask), .lane_ok(lane_ok)
  );

  assign addr_ok = addr_fmt_ok(addr_q) && lane_ok;

  pmb_txn #(.SEL_W(SEL_W), .NUM_LANES(NUM_LANES), .TIMEOUT_CYC(TIMEOUT_CYC)) u_txn (
    .clk(clk), .rst_n(rst_n),
    .cmd_evt(cmd_evt), .cmd_kind(cmd_kind), .err_clr(err_clr), .addr_ok(addr_ok),
    .lane_mask(lane_mask), .reg_addr(addr_reg(addr_q)), .cmd_data(cfg_wdata[15:0]), .sel(sel_q),
    .busy(busy), .busy_wr(busy_wr), .err(err), .rack(rack), .rdata(rdata),
    .phy_sel(phy_sel), .phy_lane_mask(phy_lane_mask), .phy_reg(phy_reg), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  assign phy_req = busy;
  assign phy_we  = busy_wr;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $fell(rst_n) |=> !phy_req); // R1

endmodule

// File: tb/phy_mgmt_bridge_bench.sv
module phy_mgmt_bridge_bench;

  localparam int TMO = 16;
  localparam logic [15:0] A_ADDR = 16'h1130, A_DATA = 16'h1134, A_RDAT = 16'h1138, A_SEL = 16'h113C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        phy_req, phy_we;
  logic [2:0]  phy_sel;
  logic [1:0]  phy_lane_mask;
  logic [15:0] phy_reg, phy_wdata;
  logic        phy_ack;
  logic [15:0] phy_rdata;

  always #5 clk = ~clk;

  phy_mgmt_bridge #(.CFG_AW(16), .NUM_MACROS(8), .NUM_LANES(2), .TIMEOUT_CYC(TMO)) u_phy_mgmt_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .phy_req(phy_req), .phy_we(phy_we), .phy_sel(phy_sel),
    .phy_lane_mask(phy_lane_mask), .phy_reg(phy_reg), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // macro model: register file per macro and lane
  logic [15:0] mem [8][2][8];
  int          lat = 3;
  logic        no_resp = 1'b0;
  int          cnt, acks;
  logic [1:0]  last_mask;
  logic [2:0]  last_sel;
  logic [15:0] last_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      phy_ack <= 1'b0; phy_rdata <= '0; cnt <= 0; acks <= 0;
      last_mask <= '0; last_sel <= '0; last_wdata <= '0;
      for (int m = 0; m < 8; m++) for (int l = 0; l < 2; l++) for (int r = 0; r < 8; r++) mem[m][l][r] <= '0;
    end else begin
      phy_ack <= 1'b0;
      if (phy_req && !phy_ack && !no_resp) begin
        if (cnt >= lat) begin
          phy_ack <= 1'b1; cnt <= 0; acks <= acks + 1;
          last_mask <= phy_lane_mask; last_sel <= phy_sel; last_wdata <= phy_wdata;
          if (phy_we) begin
            for (int l = 0; l < 2; l++) if (phy_lane_mask[l]) mem[phy_sel][l][phy_reg[2:0]] <= phy_wdata;
          end else begin
            phy_rdata <= phy_lane_mask[0] ? mem[phy_sel][0][phy_reg[2:0]] : mem[phy_sel][1][phy_reg[2:0]];
          end
        end else cnt <= cnt + 1;
      end else cnt <= 0;
    end
  end

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [15:0] sh [8][2][8] = '{default: '0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_rd(input logic [15:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 100; i++) begin
      cfg_rd(A_DATA, d);
      if (d[31:30] == 2'b00) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [8:0] lane, input logic [15:0] r);
    return (32'h1 << 27) | (32'(lane) << 16) | 32'(r);
  endfunction

  task automatic phy_wr(input logic [2:0] s, input logic [8:0] lane, input logic [15:0] r, input logic [15:0] d);
    cfg_wr(A_SEL, 32'(s)); cfg_wr(A_ADDR, mk_addr(lane, r)); cfg_wr(A_DATA, 32'h8000_0000 | 32'(d));
    wait_idle();
  endtask

  task automatic phy_rd(input logic [8:0] lane, input logic [15:0] r, output logic [31:0] d);
    cfg_wr(A_ADDR, mk_addr(lane, r)); cfg_wr(A_DATA, 32'h4000_0000);
    wait_idle(); cfg_rd(A_RDAT, d);
  endtask

  // {sel, lane, reg, data}
  localparam logic [43:0] VEC [6] = '{
    {3'd0, 9'h000, 16'hD090, 16'h4C00},
    {3'd1, 9'h001, 16'hD0A5, 16'h3C00},
    {3'd5, 9'h1FF, 16'hD0B4, 16'h1000},
    {3'd7, 9'h001, 16'hD0B4, 16'hBEEF},
    {3'd7, 9'h1FF, 16'hD011, 16'h00AA},
    {3'd3, 9'h000, 16'hD011, 16'h1155}
  };

  initial begin
    logic [31:0] d;
    int a0, n;
    repeat (3) @(negedge clk);
    // R1 reset state
    cfg_rd(A_ADDR, d); chk("R1 addr", d, 0);
    cfg_rd(A_DATA, d); chk("R1 data", d, 0);
    cfg_rd(A_RDAT, d); chk("R1 rdat", d, 0);
    cfg_rd(A_SEL, d);  chk("R1 sel", d, 0);
    chk("R1 req", 32'(phy_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register readback
    cfg_wr(A_ADDR, 32'h0A5A_F00F); cfg_rd(A_ADDR, d); chk("R2 addr", d, 32'h0A5A_F00F);
    cfg_wr(A_SEL, 32'h0000_0005);  cfg_rd(A_SEL, d);  chk("R2 sel", d, 32'h5);
    cfg_rd(16'h1140, d); chk("R2 unmapped", d, 0);

    // vector table: writes, then per-lane readback
    foreach (VEC[i]) begin
      logic [2:0] s; logic [8:0] ln; logic [15:0] r, v;
      {s, ln, r, v} = VEC[i];
      phy_wr(s, ln, r, v);
      for (int l = 0; l < 2; l++) if (ln == 9'h1FF || ln == 9'(l)) sh[s][l][r[2:0]] = v;
      for (int l = 0; l < 2; l++) begin
        phy_rd(9'(l), r, d);
        chk($sformatf("R6 vec%0d lane%0d", i, l), d, {1'b1, 15'd0, sh[s][l][r[2:0]]});
      end
    end

    // R3 in-flight bit and upper data bits dropped
    cfg_wr(A_SEL, 32'd2); cfg_wr(A_ADDR, mk_addr(9'h0, 16'hD003));
    cfg_wr(A_DATA, 32'h8F5A_1234);
    cfg_rd(A_DATA, d); chk("R3 busy bit", 32'(d[31]), 1);
    wait_idle();
    cfg_rd(A_DATA, d); chk("R3 self clear", 32'(d[31:30]), 0);
    chk("R3 low16 only", 32'(last_wdata), 32'h1234);

    // R4 read-ack and its clearing on next command
    phy_rd(9'h0, 16'hD003, d); chk("R4 rack data", d, 32'h8000_1234);
    cfg_wr(A_DATA, 32'h8000_0055);
    cfg_rd(A_RDAT, d); chk("R4 rack cleared", 32'(d[31]), 0);
    wait_idle();

    // R6 broadcast read uses lane 0
    phy_wr(3'd2, 9'h001, 16'hD006, 16'h0707);
    phy_wr(3'd2, 9'h000, 16'hD006, 16'h0606);
    phy_rd(9'h1FF, 16'hD006, d);
    chk("R6 bcast rd data", d, 32'h8000_0606);
    chk("R6 bcast rd mask", 32'(last_mask), 32'h1);

    // R5 bit 27 clear
    a0 = acks;
    cfg_wr(A_ADDR, 32'h0000_D090); cfg_wr(A_DATA, 32'h8000_0001);
    repeat (8) @(negedge clk);
    chk("R5 no txn", 32'(acks - a0), 0);
    cfg_rd(A_DATA, d); chk("R5 err", 32'(d[29]), 1);
    // R10 clear
    cfg_wr(A_DATA, 32'h2000_0000);
    cfg_rd(A_DATA, d); chk("R10 cleared", 32'(d[29]), 0);

    // R6 invalid lane
    cfg_wr(A_ADDR, mk_addr(9'h005, 16'hD001)); cfg_wr(A_DATA, 32'h4000_0000);
    repeat (8) @(negedge clk);
    chk("R6 bad lane no txn", 32'(acks - a0), 0);
    cfg_rd(A_DATA, d); chk("R6 bad lane err", 32'(d[29]), 1);
    // R10 sticky through a good transaction
    phy_wr(3'd4, 9'h000, 16'hD001, 16'h0042);
    cfg_rd(A_DATA, d); chk("R10 sticky", 32'(d[29]), 1);
    cfg_wr(A_DATA, 32'h2000_0000);

    // R8 both command bits
    a0 = acks;
    cfg_wr(A_DATA, 32'hC000_0000);
    repeat (8) @(negedge clk);
    chk("R8 no txn", 32'(acks - a0), 0);
    cfg_rd(A_DATA, d); chk("R8 err", 32'(d[29]), 1);
    cfg_wr(A_DATA, 32'h2000_0000);

    // R7 collision and R11 select hold
    lat = 8;
    a0 = acks;
    cfg_wr(A_SEL, 32'd6); cfg_wr(A_ADDR, mk_addr(9'h0, 16'hD002));
    cfg_wr(A_DATA, 32'h8000_0A0A);
    cfg_wr(A_DATA, 32'h8000_0B0B);
    cfg_wr(A_SEL, 32'd1);
    cfg_rd(A_DATA, d); chk("R7 err", 32'(d[29]), 1);
    wait_idle();
    chk("R7 one txn", 32'(acks - a0), 1);
    cfg_rd(A_DATA, d); chk("R7 data kept", 32'(d[15:0]), 32'h0A0A);
    chk("R11 sel latched", 32'(last_sel), 6);
    cfg_wr(A_SEL, 32'd6);
    phy_rd(9'h0, 16'hD002, d); chk("R7 mem", d, 32'h8000_0A0A);
    cfg_wr(A_DATA, 32'h2000_0000);
    lat = 3;

    // R9 timeout
    no_resp = 1'b1;
    cfg_wr(A_ADDR, mk_addr(9'h1, 16'hD004)); cfg_wr(A_DATA, 32'h4000_0000);
    n = 0;
    for (int i = 0; i < 100 && phy_req; i++) begin n++; @(negedge clk); end
    chk("R9 req cycles", 32'(n), TMO);
    cfg_rd(A_DATA, d); chk("R9 busy/err", {30'd0, d[31:30]} | 32'(d[29]) << 2, 32'h4);
    cfg_rd(A_RDAT, d); chk("R9 rack", 32'(d[31]), 0);
    no_resp = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule